// File: doc/BRIEF.md
# Disk Recalibrate-to-Track-Zero Sequencer

This block brings a moving-head disk back to cylinder zero before a boot read begins. After a start pulse it resets the disk controller, selects unit 0 and head 0, lets a number of sector wakeups pass, and checks that the drive reports itself selected and ready. It then arms sector wakeups and works in step with them. On each wakeup it reads the controller status word. If the heads are not yet at track zero and the previous seek has finished, it issues another outward seek. Once track zero is reported, it counts wakeups until the heads have had time to settle.

Every controller access goes out as a command word, a target code and a one-clock write strobe. After each seek command the block waits a set number of clock cycles. It then writes the command again with the seek bit cleared, which keeps wakeups enabled. The sequence ends in one of three outcomes: done, not-ready, or seek-timeout. The outcome flag stays set until the next accepted start.

Top module: `trk0_recal_seq`

## Requirements
- R1: A start pulse is taken only while `busy_o` is low. Taking it clears all three result flags and raises `busy_o`. A start pulse while busy has no effect: no command is written and the sequence carries on.
- R2: In the two clocks right after an accepted start, the block writes target 0 (controller reset) with data 0 and then target 1 (unit/head select) with data 0.
- R3: The ready bit is status bit 4 (octal 20). It is examined on the PRE_WAKES-th sector wakeup after the select write. If it is clear, `not_ready_o` is set, `busy_o` falls and no further command is written.
- R4: If the ready bit is set, the block writes target 0 with data 0, then writes target 2 (operation) with the wake-enable word octal 4000. It then starts polling. Every operation write carries either octal 4000 or octal 6000.
- R5: During polling, each wakeup tests track zero (status bit 6, octal 100) first. A wakeup that shows track zero never causes a seek, even if seek-complete is also set.
- R6: A polled wakeup without track zero but with seek-complete (status bit 5, octal 40) causes an operation write of octal 6000. After exactly SEEK_GAP_CYC+1 clocks with no strobe, an operation write of octal 4000 follows. This second word is the seek word masked with octal 5000.
- R7: Sector wakeups that arrive between the seek write and the re-arm write are ignored.
- R8: A timeout counter is loaded with SEEK_LIMIT at every wake-enable write. It counts polled wakeups that show neither track zero nor seek-complete. When the count reaches SEEK_LIMIT, `seek_timeout_o` is set and the sequence ends.
- R9: `done_o` is set on the SETTLE_WAKES-th polled wakeup that shows track zero. The count is cumulative: wakeups without track zero in between do not restart it.
- R10: At most one result flag is set at a time. The flags stay unchanged until the next accepted start. No command strobe occurs while idle.
- R11: After reset, `busy_o`, `cmd_we_o` and all three result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-clock request to begin a recalibrate |
| sector_wake_i | input | 1 | One-clock pulse per sector wakeup |
| status_i | input | 16 | Controller status word (bit 4 ready, bit 5 seek complete, bit 6 track zero) |
| cmd_we_o | output | 1 | One-clock write strobe for a controller command |
| cmd_tgt_o | output | 2 | Command target: 0 reset, 1 unit/head select, 2 operation |
| cmd_data_o | output | 16 | Command data word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Heads at track zero and settled |
| not_ready_o | output | 1 | Drive reported not ready |
| seek_timeout_o | output | 1 | Seek limit exhausted without reaching track zero |

## Verification
The bench runs a reduced configuration and sweeps the number of seeks before track zero appears. For each seek it checks the exact command order and the exact gap between the seek word and the re-arm word. It also sweeps where a seek falls before a timeout, which shows whether the counter reloads after each seek or keeps counting from the first wake-enable write. Track-zero wakeups are mixed with wakeups without it, and one track-zero wakeup is sent during a seek gap. These show whether settling is cumulative and whether wakeups in the gap are dropped. Status words with both track zero and seek-complete set show which test takes priority.

// File: rtl/recal_pkg.sv
package recal_pkg;

    localparam int STAT_W = 16;
    localparam int CMD_W  = 16;

    // status bit positions decoded from the controller
    localparam int BIT_READY    = 4;
    localparam int BIT_SEEKDONE = 5;
    localparam int BIT_TRK0     = 6;

    // operation words
    localparam logic [CMD_W-1:0] CMD_WAKE_EN = 16'o4000;
    localparam logic [CMD_W-1:0] CMD_SEEK_OUT = 16'o6000;
    localparam logic [CMD_W-1:0] CMD_KEEP_MASK = 16'o5000;

    typedef enum logic [1:0] {
        TGT_RESET  = 2'd0,
        TGT_SELECT = 2'd1,
        TGT_OP     = 2'd2
    } cmd_tgt_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_SELECT,
        ACT_ARM,
        ACT_SEEK
    } cmd_act_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_RST,
        ST_WR_SEL,
        ST_PRE,
        ST_WR_RST2,
        ST_WR_ARM,
        ST_POLL,
        ST_WR_SEEK,
        ST_GAP
    } recal_state_e;

endpackage

// File: rtl/recal_down_ctr.sv
module recal_down_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/recal_cmd_mux.sv
module recal_cmd_mux
    import recal_pkg::*;
(
    input  cmd_act_e              act_i,
    output logic                  we_o,
    output logic [1:0]            tgt_o,
    output logic [CMD_W-1:0]      data_o
);

    localparam logic [CMD_W-1:0] REARM_WORD = CMD_SEEK_OUT & CMD_KEEP_MASK;

    always_comb begin
        we_o   = 1'b1;
        tgt_o  = TGT_RESET;
        data_o = '0;
        case (act_i)
            ACT_RESET: begin
                tgt_o  = TGT_RESET;
                data_o = '0;
            end
            ACT_SELECT: begin
                tgt_o  = TGT_SELECT;
                data_o = '0;
            end
            ACT_ARM: begin
                tgt_o  = TGT_OP;
                data_o = REARM_WORD;
            end
            ACT_SEEK: begin
                tgt_o  = TGT_OP;
                data_o = CMD_SEEK_OUT;
            end
            default: begin
                we_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trk0_recal_seq.sv
module trk0_recal_seq
    import recal_pkg::*;
#(
    parameter int PRE_WAKES    = 2,
    parameter int SEEK_LIMIT   = 512,
    parameter int SETTLE_WAKES = 31,
    parameter int SEEK_GAP_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sector_wake_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              cmd_we_o,
    output logic [1:0]        cmd_tgt_o,
    output logic [CMD_W-1:0]  cmd_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              not_ready_o,
    output logic              seek_timeout_o
);

    localparam int PRE_W = $clog2(PRE_WAKES + 1);
    localparam int TO_W  = $clog2(SEEK_LIMIT + 1);
    localparam int ST_W  = $clog2(SETTLE_WAKES + 1);
    localparam int GAP_W = $clog2(SEEK_GAP_CYC + 1) + 1;

    typedef struct packed {
        recal_state_e st;
        logic         done;
        logic         nrdy;
        logic         tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic st_ready, st_seekdone, st_trk0;
    logic unused_status;
    assign st_ready      = status_i[BIT_READY];
    assign st_seekdone   = status_i[BIT_SEEKDONE];
    assign st_trk0       = status_i[BIT_TRK0];
    assign unused_status = ^status_i;

    logic             pre_load, pre_dec;
    logic             to_load, to_dec;
    logic             set_load, set_dec;
    logic             gap_load, gap_dec;
    logic [PRE_W-1:0] pre_cnt;
    logic [TO_W-1:0]  to_cnt;
    logic [ST_W-1:0]  set_cnt;
    logic [GAP_W-1:0] gap_cnt;
    cmd_act_e         act;

    always_comb begin
        ctl_d    = ctl_q;
        act      = ACT_NONE;
        pre_load = 1'b0;
        pre_dec  = 1'b0;
        to_load  = 1'b0;
        to_dec   = 1'b0;
        set_load = 1'b0;
        set_dec  = 1'b0;
        gap_load = 1'b0;
        gap_dec  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st   = ST_WR_RST;
                    ctl_d.done = 1'b0;
                    ctl_d.nrdy = 1'b0;
                    ctl_d.tmo  = 1'b0;
                end
            end
            ST_WR_RST: begin
                act      = ACT_RESET;
                ctl_d.st = ST_WR_SEL;
            end
            ST_WR_SEL: begin
                act      = ACT_SELECT;
                pre_load = 1'b1;
                set_load = 1'b1;
                ctl_d.st = ST_PRE;
            end
            ST_PRE: begin
                if (sector_wake_i) begin
                    if (pre_cnt == PRE_W'(1)) begin
                        if (st_ready) begin
                            ctl_d.st = ST_WR_RST2;
                        end else begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.nrdy = 1'b1;
                        end
                    end else begin
                        pre_dec = 1'b1;
                    end
                end
            end
            ST_WR_RST2: begin
                act      = ACT_RESET;
                ctl_d.st = ST_WR_ARM;
            end
            ST_WR_ARM: begin
                act      = ACT_ARM;
                to_load  = 1'b1;
                ctl_d.st = ST_POLL;
            end
            ST_POLL: begin
                if (sector_wake_i) begin
                    if (st_trk0) begin
                        if (set_cnt == ST_W'(1)) begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                        end else begin
                            set_dec = 1'b1;
                        end
                    end else if (st_seekdone) begin
                        ctl_d.st = ST_WR_SEEK;
                    end else if (to_cnt == TO_W'(1)) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.tmo = 1'b1;
                    end else begin
                        to_dec = 1'b1;
                    end
                end
            end
            ST_WR_SEEK: begin
                act      = ACT_SEEK;
                gap_load = 1'b1;
                ctl_d.st = ST_GAP;
            end
            ST_GAP: begin
                if (gap_cnt == '0) begin
                    ctl_d.st = ST_WR_ARM;
                end else begin
                    gap_dec = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, done: 1'b0, nrdy: 1'b0, tmo: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    recal_down_ctr #(.W(PRE_W)) u_pre_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(pre_load),
        .load_val_i(PRE_W'(PRE_WAKES)), .dec_i(pre_dec), .cnt_o(pre_cnt)
    );

    recal_down_ctr #(.W(TO_W)) u_tmo_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(to_load),
        .load_val_i(TO_W'(SEEK_LIMIT)), .dec_i(to_dec), .cnt_o(to_cnt)
    );

    recal_down_ctr #(.W(ST_W)) u_settle_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(set_load),
        .load_val_i(ST_W'(SETTLE_WAKES)), .dec_i(set_dec), .cnt_o(set_cnt)
    );

    recal_down_ctr #(.W(GAP_W)) u_gap_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(gap_load),
        .load_val_i(GAP_W'(SEEK_GAP_CYC)), .dec_i(gap_dec), .cnt_o(gap_cnt)
    );

    recal_cmd_mux u_cmd_mux (
        .act_i(act), .we_o(cmd_we_o), .tgt_o(cmd_tgt_o), .data_o(cmd_data_o)
    );

    assign busy_o         = (ctl_q.st != ST_IDLE);
    assign done_o         = ctl_q.done;
    assign not_ready_o    = ctl_q.nrdy;
    assign seek_timeout_o = ctl_q.tmo;

endmodule

module recal_chk
    import recal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              sector_wake_i,
    input logic [STAT_W-1:0] status_i,
    input logic              cmd_we_o,
    input logic [1:0]        cmd_tgt_o,
    input logic [CMD_W-1:0]  cmd_data_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              not_ready_o,
    input logic              seek_timeout_o
);

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done_o, not_ready_o, seek_timeout_o}) <= 1); // R10

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_we_o); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({done_o, not_ready_o, seek_timeout_o})); // R10

    AST_OP_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && cmd_tgt_o == TGT_OP) |->
        (cmd_data_o == CMD_WAKE_EN || cmd_data_o == CMD_SEEK_OUT)); // R4

    AST_SEEK_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && cmd_tgt_o == TGT_OP && cmd_data_o == CMD_SEEK_OUT) |=> !cmd_we_o); // R6

    AST_NO_SEEK_AT_TRK0: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sector_wake_i && status_i[BIT_TRK0]) |=>
        !(cmd_we_o && cmd_data_o == CMD_SEEK_OUT)); // R5

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sector_wake_i && status_i[BIT_TRK0])); // R9

    AST_NRDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(not_ready_o) |-> $past(sector_wake_i && !status_i[BIT_READY])); // R3

    AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seek_timeout_o) |->
        $past(sector_wake_i && !status_i[BIT_TRK0] && !status_i[BIT_SEEKDONE])); // R8

endmodule

bind trk0_recal_seq recal_chk u_recal_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sector_wake_i(sector_wake_i),
    .status_i(status_i), .cmd_we_o(cmd_we_o), .cmd_tgt_o(cmd_tgt_o),
    .cmd_data_o(cmd_data_o), .busy_o(busy_o), .done_o(done_o),
    .not_ready_o(not_ready_o), .seek_timeout_o(seek_timeout_o)
);

// File: tb/test_trk0_recal_seq.sv
`timescale 1ns/1ps
module test_trk0_recal_seq;

    localparam int PW = 2;
    localparam int SL = 6;
    localparam int SW = 3;
    localparam int GC = 4;

    localparam logic [15:0] S_RDY  = 16'h0010;
    localparam logic [15:0] S_SKD  = 16'h0020;
    localparam logic [15:0] S_TRK  = 16'h0040;
    localparam logic [15:0] W_ARM  = 16'o4000;
    localparam logic [15:0] W_SEEK = 16'o6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wake = 1'b0;
    logic [15:0] stat = '0;
    logic        cmd_we, busy, done, nrdy, tmo;
    logic [1:0]  cmd_tgt;
    logic [15:0] cmd_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_wr = 0;
    int lg_tgt [64];
    int lg_dat [64];
    int lg_cyc [64];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    trk0_recal_seq #(
        .PRE_WAKES(PW), .SEEK_LIMIT(SL), .SETTLE_WAKES(SW), .SEEK_GAP_CYC(GC)
    ) i_trk0_recal_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sector_wake_i(wake),
        .status_i(stat), .cmd_we_o(cmd_we), .cmd_tgt_o(cmd_tgt),
        .cmd_data_o(cmd_data), .busy_o(busy), .done_o(done),
        .not_ready_o(nrdy), .seek_timeout_o(tmo)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && cmd_we) begin
            if (n_wr < 64) begin
                lg_tgt[n_wr] = int'(cmd_tgt);
                lg_dat[n_wr] = int'(cmd_data);
                lg_cyc[n_wr] = cyc;
            end
            n_wr = n_wr + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        step(GC + 6);
    endtask

    task automatic do_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
        step(3);
    endtask

    task automatic to_poll();
        stat = S_RDY;
        do_start();
        pulse_wake();
        pulse_wake();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            finish_run();
        end
    end

    initial begin
        int b;
        step(3);
        // R11 reset state
        chk("R11 busy", int'(busy), 0);
        chk("R11 we", int'(cmd_we), 0);
        chk("R11 flags", int'({done, nrdy, tmo}), 0);
        rst_n = 1'b1;
        step(2);

        // R1 R2 R3: drive not ready
        stat = '0;
        b = n_wr;
        do_start();
        chk("R1 busy after start", int'(busy), 1);
        chk("R2 write count", n_wr - b, 2);
        chk("R2 first target", lg_tgt[b], 0);
        chk("R2 first data", lg_dat[b], 0);
        chk("R2 second target", lg_tgt[b+1], 1);
        chk("R2 second data", lg_dat[b+1], 0);
        pulse_wake();
        chk("R3 still waiting", int'(busy), 1);
        pulse_wake();
        chk("R3 not ready", int'(nrdy), 1);
        chk("R3 idle", int'(busy), 0);
        chk("R3 no more writes", n_wr - b, 2);
        pulse_wake();
        pulse_wake();
        chk("R10 flag held", int'({done, nrdy, tmo}), 2);
        chk("R10 no writes idle", n_wr - b, 2);

        // R4 R5 R9: already at track zero, seek-complete also set
        stat = S_RDY | S_TRK | S_SKD;
        b = n_wr;
        do_start();
        chk("R1 flags cleared", int'({done, nrdy, tmo}), 0);
        pulse_wake();
        pulse_wake();
        chk("R4 write count", n_wr - b, 4);
        chk("R4 reset target", lg_tgt[b+2], 0);
        chk("R4 arm target", lg_tgt[b+3], 2);
        chk("R4 arm data", lg_dat[b+3], int'(W_ARM));
        for (int i = 0; i < SW - 1; i++) pulse_wake();
        chk("R9 not yet done", int'(done), 0);
        pulse_wake();
        chk("R9 done", int'(done), 1);
        chk("R9 idle", int'(busy), 0);
        chk("R5 no seek at trk0", n_wr - b, 4);

        // R6: sweep number of seeks
        for (int k = 1; k <= 3; k++) begin
            b = n_wr;
            to_poll();
            stat = S_RDY | S_SKD;
            for (int i = 0; i < k; i++) begin
                pulse_wake();
                chk("R6 seek data", lg_dat[n_wr-2], int'(W_SEEK));
                chk("R6 seek target", lg_tgt[n_wr-2], 2);
                chk("R6 rearm data", lg_dat[n_wr-1], int'(W_ARM));
                chk("R6 gap", lg_cyc[n_wr-1] - lg_cyc[n_wr-2], GC + 2);
            end
            chk("R6 total writes", n_wr - b, 4 + 2 * k);
            stat = S_RDY | S_TRK;
            for (int i = 0; i < SW; i++) pulse_wake();
            chk("R6 done after seeks", int'(done), 1);
        end

        // R8: timeout with a seek at position j reloading the counter
        for (int j = 0; j < 3; j++) begin
            to_poll();
            stat = S_RDY;
            for (int i = 0; i < j; i++) pulse_wake();
            stat = S_RDY | S_SKD;
            pulse_wake();
            stat = S_RDY;
            for (int i = 0; i < SL - 1; i++) pulse_wake();
            chk("R8 not yet timed out", int'(tmo), 0);
            chk("R8 still busy", int'(busy), 1);
            pulse_wake();
            chk("R8 timeout", int'(tmo), 1);
            chk("R8 not done", int'(done), 0);
            chk("R8 idle", int'(busy), 0);
        end

        // R9: settle count is cumulative across wakeups without track zero
        to_poll();
        stat = S_RDY | S_TRK;
        pulse_wake();
        stat = S_RDY;
        pulse_wake();
        stat = S_RDY | S_TRK;
        for (int i = 0; i < SW - 2; i++) pulse_wake();
        chk("R9 cumulative not yet", int'(done), 0);
        pulse_wake();
        chk("R9 cumulative done", int'(done), 1);

        // R7: track-zero wakeup during the seek gap is ignored
        to_poll();
        stat = S_RDY | S_SKD;
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        stat = S_RDY | S_TRK;
        step(1);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        step(GC + 6);
        for (int i = 0; i < SW - 1; i++) pulse_wake();
        chk("R7 gap wake ignored", int'(done), 0);
        pulse_wake();
        chk("R7 done after full count", int'(done), 1);

        // R1: start while busy ignored
        b = n_wr;
        to_poll();
        do_start();
        chk("R1 restart ignored writes", n_wr - b, 4);
        chk("R1 still busy", int'(busy), 1);
        stat = S_RDY | S_TRK;
        for (int i = 0; i < SW; i++) pulse_wake();
        chk("R1 finishes normally", int'(done), 1);

        finished = 1'b1;
        finish_run();
    end

endmodule